// File: doc/BRIEF.md
# Keyed Write-Protect Sequencer

This block sits in front of a page-write memory engine and watches every write the host presents to it. It keeps a protect flag that survives across writes. For each write it decides one of three outcomes. The byte can be loaded for programming (commit). It can be consumed as key data that is never stored (suppress). Or it can be dropped silently while the engine still runs a dummy program cycle, so that host polling behaves as it would after a real write. Writes arrive in load windows: a window stays open while the gap between accepted writes is at most `LOAD_WINDOW` cycles. When a window closes, the block raises a one-cycle start-timer pulse that tells the engine to program.

Two keys are recognised at the start of a window. The arming key is three writes: AA at 5555, then 55 at 2AAA, then A0 at 5555. The clearing key is six writes: AA at 5555, 55 at 2AAA, 80 at 5555, AA at 5555, 55 at 2AAA, then 20 at 5555. Every address and data value of both keys is a parameter. Writes that follow a complete key in the same window are committed even while protection is on. The flag changes only when the program cycle started after that window finishes, which the block sees as the engine's busy signal falling.

Top module: `wp_seq_guard`

## Requirements
- R1: During and after reset, `commit_o`, `suppress_o` and `timer_o` are low and `prot_o` equals the `PROT_INIT` parameter.
- R2: With protection off, a write that does not start a key pulses `commit_o` for one cycle, on the cycle after the write strobe is sampled. Once no accepted write has arrived for `LOAD_WINDOW` cycles, `timer_o` pulses exactly once.
- R3: Each write of the arming key (data AA at address 5555, 55 at 2AAA, A0 at 5555, in that order) pulses `suppress_o` and never `commit_o`. When its window closes, `timer_o` pulses. `prot_o` then rises at the first clock edge that samples `eng_busy` low after it was high.
- R4: With protection on, a write that is neither key data nor inside a keyed window produces no `commit_o` and no `suppress_o`. When its window closes, `timer_o` still pulses, and `prot_o` stays set.
- R5: With protection on, writes that follow a complete arming key in the same window are committed through `commit_o`, and protection stays set afterwards.
- R6: The clearing key (AA at 5555, 55 at 2AAA, 80 at 5555, AA at 5555, 55 at 2AAA, 20 at 5555) has each of its writes suppressed. The window end pulses `timer_o`, and `prot_o` falls when `eng_busy` next falls.
- R7: A write that mismatches the expected key step in address or data returns the matcher to idle. That write is handled as an ordinary write (committed if unprotected, dropped if protected), and the key writes before it stay unstored.
- R8: A gap of more than `LOAD_WINDOW` cycles inside a key aborts it without a `timer_o` pulse. A later write that would have continued the key is handled as an ordinary write.
- R9: A write strobe sampled while `eng_busy` is high is ignored. It produces no output and does not advance the key matcher.
- R10: The key addresses are ordinary locations: a write to address 5555 with data other than AA commits while protection is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| eng_busy | input | 1 | Engine is running a program cycle |
| commit_o | output | 1 | Pulse: store this byte |
| suppress_o | output | 1 | Pulse: byte consumed as key data |
| timer_o | output | 1 | Pulse: start a program cycle |
| prot_o | output | 1 | Protect flag |

## Verification
The bench aims at the places where a key matcher tends to slip. The third key step branches two ways, toward arming or toward the longer clearing key. A design that mixes up the branches arms when it should clear, or leaves the flag unchanged. A key split by a gap longer than the window must be aborted. A design that keeps matching would swallow the resuming write as key data instead of dropping it. Strobes sampled while the engine is busy are sent with key values, so a design that still counts them shows spurious suppress pulses. A mid-key mismatch and guarded writes under protection check that a write is committed exactly when protection is off or a full arming key came first.

// File: rtl/wp_seq_guard.sv
module wp_seq_guard #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int LOAD_WINDOW = 16,
  parameter bit PROT_INIT   = 1'b0,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A   = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B   = 15'h2AAA,
  parameter logic [DATA_W-1:0] KEY_OPEN1    = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_OPEN2    = 8'h55,
  parameter logic [DATA_W-1:0] KEY_ARM      = 8'hA0,
  parameter logic [DATA_W-1:0] KEY_CLR_PRE  = 8'h80,
  parameter logic [DATA_W-1:0] KEY_CLR      = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  output logic              commit_o,
  output logic              suppress_o,
  output logic              timer_o,
  output logic              prot_o
);

  localparam int CNT_W = $clog2(LOAD_WINDOW + 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(LOAD_WINDOW - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_KEY, PH_GUARD, PH_LOAD} ph_t;

  ph_t              ph_q;
  logic [2:0]       step_q;
  logic             guard_val_q;
  logic [CNT_W-1:0] gap_q;
  logic             pend_q, pend_val_q, busy_q, prot_q;
  logic             commit_q, suppress_q, timer_q;

  logic              acc, keying, hit, arm_done, clr_done, expire;
  logic [2:0]        cur_step;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;

  assign acc      = wr_stb && !eng_busy;
  assign keying   = (ph_q == PH_IDLE) || (ph_q == PH_KEY);
  assign cur_step = (ph_q == PH_KEY) ? step_q : 3'd0;
  assign exp_addr = (cur_step == 3'd1 || cur_step == 3'd4) ? KEY_ADDR_B : KEY_ADDR_A;

  always_comb begin
    case (cur_step)
      3'd0, 3'd3: exp_data = KEY_OPEN1;
      3'd1, 3'd4: exp_data = KEY_OPEN2;
      3'd2:       exp_data = KEY_CLR_PRE;
      default:    exp_data = KEY_CLR;
    endcase
  end

  assign arm_done = (cur_step == 3'd2) && (wr_addr == KEY_ADDR_A) && (wr_data == KEY_ARM);
  assign hit      = arm_done || ((wr_addr == exp_addr) && (wr_data == exp_data));
  assign clr_done = (cur_step == 3'd5) && hit;
  assign expire   = !acc && (ph_q != PH_IDLE) && (gap_q == GAP_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      step_q      <= 3'd0;
      guard_val_q <= 1'b0;
      gap_q       <= '0;
      pend_q      <= 1'b0;
      pend_val_q  <= 1'b0;
      busy_q      <= 1'b0;
      prot_q      <= PROT_INIT;
      commit_q    <= 1'b0;
      suppress_q  <= 1'b0;
      timer_q     <= 1'b0;
    end else begin
      busy_q     <= eng_busy;
      commit_q   <= 1'b0;
      suppress_q <= 1'b0;
      timer_q    <= 1'b0;

      if (acc) gap_q <= '0;
      else if (ph_q != PH_IDLE && gap_q != GAP_LAST) gap_q <= gap_q + 1'b1;

      if (acc) begin
        if (keying && hit) begin
          suppress_q <= 1'b1;
          if (arm_done || clr_done) begin
            ph_q        <= PH_GUARD;
            guard_val_q <= arm_done;
            step_q      <= 3'd0;
          end else begin
            ph_q   <= PH_KEY;
            step_q <= cur_step + 3'd1;
          end
        end else if (ph_q == PH_GUARD) begin
          commit_q <= 1'b1;
        end else begin
          commit_q <= !prot_q;
          ph_q     <= PH_LOAD;
          step_q   <= 3'd0;
        end
      end else if (expire) begin
        timer_q <= (ph_q == PH_GUARD) || (ph_q == PH_LOAD);
        if (ph_q == PH_GUARD) begin
          pend_q     <= 1'b1;
          pend_val_q <= guard_val_q;
        end
        ph_q   <= PH_IDLE;
        step_q <= 3'd0;
      end

      if (pend_q && busy_q && !eng_busy) begin
        prot_q <= pend_val_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign commit_o   = commit_q;
  assign suppress_o = suppress_q;
  assign timer_o    = timer_q;
  assign prot_o     = prot_q;

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || suppress_o) |-> ($past(wr_stb) && !$past(eng_busy))); // R9
  AST_LOCKED_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!$past(prot_o) || $past(ph_q) == PH_GUARD)); // R4
  AST_PROT_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_o) |-> ($past(busy_q) && !$past(eng_busy))); // R3
  AST_TIMER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_o |=> !timer_o); // R2
  AST_TIMER_QUIET_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    timer_o |-> !$past(acc)); // R2
  AST_KEY_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_o |-> !commit_o); // R3

endmodule

// File: tb/sim_wp_seq_guard.sv
module sim_wp_seq_guard;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        model_busy = 1'b0;
  logic        tb_busy = 1'b0;
  logic        eng_busy;
  logic        commit_o, suppress_o, timer_o, prot_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  assign eng_busy = model_busy | tb_busy;

  always #4 clk = ~clk;

  wp_seq_guard #(.LOAD_WINDOW(W), .PROT_INIT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .commit_o(commit_o), .suppress_o(suppress_o),
    .timer_o(timer_o), .prot_o(prot_o)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // codes: {timer, suppress, commit}
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic [2:0] code, input string tag);
    if (code != 3'b000) begin
      exp_q.push_back(code);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic expect_timer(input string tag);
    exp_q.push_back(3'b100);
    tag_q.push_back(tag);
  endtask

  task automatic settle(input string tag);
    repeat (W + 25) @(negedge clk);
    check(exp_q.size() == 0, {tag, " pending events"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin : monitor
    logic [2:0] got, e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && (commit_o || suppress_o || timer_o)) begin
        got = {timer_o, suppress_o, commit_o};
        if (exp_q.size() == 0) check(1'b0, "unexpected event", got, 0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, got, e);
        end
      end
    end
  end

  initial begin : busy_model
    forever begin
      @(negedge clk);
      if (timer_o) begin
        model_busy = 1'b1;
        repeat (10) @(negedge clk);
        model_busy = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check({commit_o, suppress_o, timer_o, prot_o} == 4'b0000, "R1 reset state",
          {commit_o, suppress_o, timer_o, prot_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({commit_o, suppress_o, timer_o, prot_o} == 4'b0000, "R1 after reset",
          {commit_o, suppress_o, timer_o, prot_o}, 0);

    wr(15'h0100, 8'h3C, 3'b001, "R2 commit 1");
    wr(15'h0101, 8'hC3, 3'b001, "R2 commit 2");
    expect_timer("R2 window timer");
    settle("R2");

    wr(15'h5555, 8'h42, 3'b001, "R10 key address write");
    expect_timer("R10 timer");
    settle("R10");
    check(prot_o == 1'b0, "R10 prot unchanged", prot_o, 0);

    wr(15'h5555, 8'hAA, 3'b010, "R3 arm key 1");
    wr(15'h2AAA, 8'h55, 3'b010, "R3 arm key 2");
    wr(15'h5555, 8'hA0, 3'b010, "R3 arm key 3");
    expect_timer("R3 timer");
    settle("R3");
    check(prot_o == 1'b1, "R3 prot set", prot_o, 1);

    wr(15'h0200, 8'h11, 3'b000, "R4 blocked");
    wr(15'h0201, 8'h12, 3'b000, "R4 blocked");
    expect_timer("R4 dummy timer");
    settle("R4");
    check(prot_o == 1'b1, "R4 prot kept", prot_o, 1);

    wr(15'h5555, 8'hAA, 3'b010, "R5 key 1");
    wr(15'h2AAA, 8'h55, 3'b010, "R5 key 2");
    wr(15'h5555, 8'hA0, 3'b010, "R5 key 3");
    wr(15'h0300, 8'h5A, 3'b001, "R5 guarded commit 1");
    wr(15'h0301, 8'hA5, 3'b001, "R5 guarded commit 2");
    expect_timer("R5 timer");
    settle("R5");
    check(prot_o == 1'b1, "R5 prot kept", prot_o, 1);

    wr(15'h5555, 8'hAA, 3'b010, "R7 key 1");
    wr(15'h2AAA, 8'h77, 3'b000, "R7 mismatch blocked");
    expect_timer("R7 timer");
    settle("R7 protected");
    check(prot_o == 1'b1, "R7 prot kept", prot_o, 1);

    wr(15'h5555, 8'hAA, 3'b010, "R8 key 1");
    wr(15'h2AAA, 8'h55, 3'b010, "R8 key 2");
    repeat (W + 6) @(negedge clk);
    check(exp_q.size() == 0, "R8 no timer on abort", exp_q.size(), 0);
    wr(15'h5555, 8'hA0, 3'b000, "R8 resumed write blocked");
    expect_timer("R8 timer");
    settle("R8");
    check(prot_o == 1'b1, "R8 prot kept", prot_o, 1);

    @(negedge clk);
    tb_busy = 1'b1;
    wr(15'h5555, 8'hAA, 3'b000, "R9 busy ignored 1");
    wr(15'h2AAA, 8'h55, 3'b000, "R9 busy ignored 2");
    tb_busy = 1'b0;
    wr(15'h2AAA, 8'h55, 3'b000, "R9 not key step");
    expect_timer("R9 timer");
    settle("R9");
    check(prot_o == 1'b1, "R9 prot kept", prot_o, 1);

    wr(15'h5555, 8'hAA, 3'b010, "R6 clr 1");
    wr(15'h2AAA, 8'h55, 3'b010, "R6 clr 2");
    wr(15'h5555, 8'h80, 3'b010, "R6 clr 3");
    wr(15'h5555, 8'hAA, 3'b010, "R6 clr 4");
    wr(15'h2AAA, 8'h55, 3'b010, "R6 clr 5");
    wr(15'h5555, 8'h20, 3'b010, "R6 clr 6");
    expect_timer("R6 timer");
    settle("R6");
    check(prot_o == 1'b0, "R6 prot cleared", prot_o, 0);

    wr(15'h5555, 8'hAA, 3'b010, "R7 key 1 open");
    wr(15'h2AAA, 8'h55, 3'b010, "R7 key 2 open");
    wr(15'h1234, 8'h99, 3'b001, "R7 mismatch commits");
    expect_timer("R7 timer open");
    settle("R7 open");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule